// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a DDR SDRAM on each rising clock edge. It decodes the pins into a command and runs a state machine for each bank. The state machines cover idle, opening (row activation), open, read burst, read with auto-precharge, write burst, write recovery, write with auto-precharge, closing (precharge) and refresh. Every transitional state lasts for a parameterised number of cycles. The block is meant for a memory controller or a protocol monitor that has to know, one cycle after each command, whether the command was allowed and where the addressed bank ended up.

When a command is not allowed in the current state of its bank (or of the device), the block raises `illegal_o` and leaves every state machine as it was, apart from its normal countdown. For every command the block also reports the resulting state of the addressed bank. All bank states are available as a packed vector. The block does not drive data pins, does not run device initialisation and does not model mode-register writes.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: `cmd_o` reports, one cycle after the sampling edge, the decoded code. /CS high gives 0 (deselect). With /CS low, {RAS,CAS,WE} decodes as follows: 111 gives 1 (NOP), 110 gives 2 (burst stop), 101 gives 3 (read, or 4 if A10 is high), 100 gives 5 (write, or 6 if A10 is high), 011 gives 7 (activate), 010 gives 8 (precharge one bank, or 9 for all banks if A10 is high), 001 gives 10 (refresh) and 000 gives 11 (unsupported, always illegal).
- R2: While reset is active and right after it, every bank is in state 0 (idle), and `illegal_o` and `cmd_o` are 0. State codes: 0 idle, 1 opening, 2 open, 3 read, 4 read+AP, 5 write, 6 write recovery, 7 write+AP, 8 closing, 9 refresh.
- R3: Activate is legal only on an idle bank. The bank is then opening for T_RCD cycles, after which it is open. Any command other than NOP or deselect aimed at an opening bank is illegal, including a command on the cycle the bank becomes open.
- R4: Read is legal in states 2 and 3. The bank is then in read (or read+AP) for BL/2+CL cycles. After that it returns to open, or after read+AP it goes to closing.
- R5: Write is legal in states 2, 5 and 6. The bank is then in write for BL/2 cycles and in write recovery for T_WR cycles, after which it is open. Write+AP holds for BL/2+T_WR cycles and then goes to closing.
- R6: Single-bank precharge is legal in states 0, 2, 3 and 6. An idle bank stays idle. Any other bank is closing for T_RP cycles and then idle.
- R7: Precharge-all is legal only if every bank is in state 0, 2, 3 or 6, and it then applies to all banks.
- R8: Refresh is legal only when all banks are idle. Every bank is then in refresh for T_RFC cycles and then idle.
- R9: On a bank in read+AP or write+AP, burst stop, read, write, activate and precharge are illegal. NOP and deselect leave the bank in place.
- R10: A write is illegal while any bank is in state 3 or 4. A burst stop on a bank in read or write returns it to open at once.
- R11: An illegal command sets `illegal_o` for exactly that one cycle and changes no bank state except through its countdown.
- R12: `next_state_o` equals the state, after the edge, of the bank that was addressed by `ba_i`.
- R13: A command aimed at one bank does not change the state or timing of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | $clog2(NB) | Bank address |
| a10_i | input | 1 | Auto-precharge / all-banks select |
| cmd_o | output | 4 | Decoded command code of the last edge |
| illegal_o | output | 1 | Last command was not allowed |
| next_state_o | output | 4 | State of the addressed bank after the edge |
| bank_state_o | output | 4*NB | Packed states of all banks, bank 0 in the low nibble |

## Verification
A command can arrive on the very edge at which a bank's timer expires. Whether that command is judged against the old state or the new state decides its legality. The bench covers this by sweeping the gap between activate and read, and between read and write, across the expiry cycle. It also issues a write on the cycle a read burst on another bank ends. A behavioural reference model, updated every clock with its own countdowns, compares the decoded code, the flag and every bank state on each cycle.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0, ST_OPENING = 4'd1, ST_OPEN = 4'd2, ST_RD = 4'd3,
    ST_RD_AP = 4'd4, ST_WR = 4'd5, ST_WR_REC = 4'd6, ST_WR_AP = 4'd7,
    ST_CLOSING = 4'd8, ST_REFRESH = 4'd9
  } bank_st_e;

  typedef enum logic [3:0] {
    C_DESL = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_RD = 4'd3, C_RDA = 4'd4,
    C_WR = 4'd5, C_WRA = 4'd6, C_ACT = 4'd7, C_PRE = 4'd8, C_PALL = 4'd9,
    C_REF = 4'd10, C_UNSUP = 4'd11
  } cmd_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_trk_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic a10_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n_i) cmd_o = C_DESL;
    else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  cmd_o = C_NOP;
        3'b110:  cmd_o = C_BST;
        3'b101:  cmd_o = a10_i ? C_RDA : C_RD;
        3'b100:  cmd_o = a10_i ? C_WRA : C_WR;
        3'b011:  cmd_o = C_ACT;
        3'b010:  cmd_o = a10_i ? C_PALL : C_PRE;
        3'b001:  cmd_o = C_REF;
        default: cmd_o = C_UNSUP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_trk_pkg::*;
#(
  parameter int BL    = 4,
  parameter int CL    = 2,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RFC = 8,
  parameter int T_WR  = 2,
  parameter int CW    = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cmd_e     cmd_i,
  input  logic     sel_i,
  input  logic     go_i,
  output bank_st_e state_o,
  output logic     ok_o
);
  localparam int RD_LEN  = BL / 2 + CL;
  localparam int WR_LEN  = BL / 2;
  localparam int WAP_LEN = BL / 2 + T_WR;

  bank_st_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic take;

  // legality of cmd_i against this bank's own state
  always_comb begin
    unique case (cmd_i)
      C_DESL, C_NOP: ok_o = 1'b1;
      C_ACT:         ok_o = (state_q == ST_IDLE);
      C_RD, C_RDA:   ok_o = state_q inside {ST_OPEN, ST_RD};
      C_WR, C_WRA:   ok_o = state_q inside {ST_OPEN, ST_WR, ST_WR_REC};
      C_BST:         ok_o = state_q inside {ST_OPEN, ST_RD, ST_WR, ST_WR_REC};
      C_PRE, C_PALL: ok_o = state_q inside {ST_IDLE, ST_OPEN, ST_RD, ST_WR_REC};
      C_REF:         ok_o = (state_q == ST_IDLE);
      default:       ok_o = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    take    = 1'b0;
    if (go_i && sel_i) begin
      unique case (cmd_i)
        C_ACT: begin state_d = ST_OPENING; cnt_d = CW'(T_RCD - 1);  take = 1'b1; end
        C_RD:  begin state_d = ST_RD;      cnt_d = CW'(RD_LEN - 1); take = 1'b1; end
        C_RDA: begin state_d = ST_RD_AP;   cnt_d = CW'(RD_LEN - 1); take = 1'b1; end
        C_WR:  begin state_d = ST_WR;      cnt_d = CW'(WR_LEN - 1); take = 1'b1; end
        C_WRA: begin state_d = ST_WR_AP;   cnt_d = CW'(WAP_LEN - 1); take = 1'b1; end
        C_REF: begin state_d = ST_REFRESH; cnt_d = CW'(T_RFC - 1);  take = 1'b1; end
        C_BST: if (state_q inside {ST_RD, ST_WR}) begin
          state_d = ST_OPEN; take = 1'b1;
        end
        C_PRE, C_PALL: if (state_q != ST_IDLE) begin
          state_d = ST_CLOSING; cnt_d = CW'(T_RP - 1); take = 1'b1;
        end
        default: ;
      endcase
    end
    if (!take && !(state_q inside {ST_IDLE, ST_OPEN})) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      else begin
        unique case (state_q)
          ST_OPENING, ST_RD, ST_WR_REC: state_d = ST_OPEN;
          ST_WR:                 begin state_d = ST_WR_REC;  cnt_d = CW'(T_WR - 1); end
          ST_RD_AP, ST_WR_AP:    begin state_d = ST_CLOSING; cnt_d = CW'(T_RP - 1); end
          default:               state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  assert_open_from_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPENING && $past(state_q) != ST_OPENING) |-> $past(state_q) == ST_IDLE);

  assert_idle_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) != ST_IDLE)
      |-> $past(state_q) inside {ST_CLOSING, ST_REFRESH});

  assert_wap_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_q) == ST_WR_AP |-> state_q inside {ST_WR_AP, ST_CLOSING});

  assert_rap_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_q) == ST_RD_AP |-> state_q inside {ST_RD_AP, ST_CLOSING});
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BL    = 4,
  parameter int CL    = 2,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RFC = 8,
  parameter int T_WR  = 2,
  localparam int BA_W = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_n_i,
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  output logic [3:0]      cmd_o,
  output logic            illegal_o,
  output logic [3:0]      next_state_o,
  output logic [NB*4-1:0] bank_state_o
);
  localparam int RD_LEN = BL / 2 + CL;
  localparam int WA_LEN = BL / 2 + T_WR;
  localparam int M1 = (T_RFC > RD_LEN) ? T_RFC : RD_LEN;
  localparam int M2 = (WA_LEN > T_RCD) ? WA_LEN : T_RCD;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int T_MAX = (M3 > T_RP) ? M3 : T_RP;
  localparam int CW = $clog2(T_MAX + 1);

  cmd_e            cmd, cmd_q;
  logic            legal, illegal_q;
  logic [BA_W-1:0] ba_q;
  logic [NB-1:0]   ok, sel, reading, idle;
  bank_st_e        st [NB];

  ddr_cmd_decode u_dec (
    .cs_n_i (cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i),
    .we_n_i (we_n_i), .a10_i  (a10_i),   .cmd_o  (cmd)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign sel[b]     = (cmd == C_PALL) || (cmd == C_REF) || (ba_i == BA_W'(b));
    assign reading[b] = st[b] inside {ST_RD, ST_RD_AP};
    assign idle[b]    = (st[b] == ST_IDLE);
    assign bank_state_o[b*4 +: 4] = st[b];

    ddr_bank_fsm #(
      .BL(BL), .CL(CL), .T_RCD(T_RCD), .T_RP(T_RP),
      .T_RFC(T_RFC), .T_WR(T_WR), .CW(CW)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd),
      .sel_i  (sel[b]),
      .go_i   (legal),
      .state_o(st[b]),
      .ok_o   (ok[b])
    );
  end

  // device-wide rules on top of the per-bank check
  always_comb begin
    unique case (cmd)
      C_PALL:      legal = &ok;
      C_REF:       legal = &idle;
      C_WR, C_WRA: legal = ok[ba_i] && !(|reading);
      default:     legal = ok[ba_i];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= C_DESL;
      illegal_q <= 1'b0;
      ba_q      <= '0;
    end else begin
      cmd_q     <= cmd;
      illegal_q <= !legal;
      ba_q      <= ba_i;
    end
  end

  assign cmd_o        = cmd_q;
  assign illegal_o    = illegal_q;
  assign next_state_o = st[ba_q];

  assert_ref_all_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_REF && !illegal_o) |-> $past(&idle));

  assert_wr_no_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o inside {C_WR, C_WRA} && !illegal_o) |-> $past(reading) == '0);

  assert_unsup_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_UNSUP |-> illegal_o);

  assert_ref_enters_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_REF && !illegal_o) |-> (bank_state_o == {NB{4'd9}}));
endmodule

// File: tb/ddr_cmd_tracker_tb.sv
module ddr_cmd_tracker_tb;
  localparam int NB = 4, BL = 4, CL = 2, T_RCD = 3, T_RP = 3, T_RFC = 8, T_WR = 2;
  localparam int BA_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [BA_W-1:0] ba = '0;
  logic [3:0] cmd_o, next_state_o;
  logic illegal_o;
  logic [NB*4-1:0] bank_state_o;

  int checks = 0, errors = 0;
  int st [NB];
  int rem [NB];
  int exp_cmd = 0, exp_ill = 0, exp_ba = 0;

  always #5 clk = ~clk;

  ddr_cmd_tracker #(.NB(NB), .BL(BL), .CL(CL), .T_RCD(T_RCD), .T_RP(T_RP),
                    .T_RFC(T_RFC), .T_WR(T_WR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .ba_i(ba), .a10_i(a10), .cmd_o(cmd_o), .illegal_o(illegal_o),
    .next_state_o(next_state_o), .bank_state_o(bank_state_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: one call per clock edge
  task automatic model(int cs, int ras, int cas, int we, int b, int a);
    int c, s;
    bit lg, any_rd, all_ok, all_idle, take;
    if (cs != 0) c = 0;
    else case (ras * 4 + cas * 2 + we)
      7: c = 1;
      6: c = 2;
      5: c = (a != 0) ? 4 : 3;
      4: c = (a != 0) ? 6 : 5;
      3: c = 7;
      2: c = (a != 0) ? 9 : 8;
      1: c = 10;
      default: c = 11;
    endcase
    any_rd = 0; all_ok = 1; all_idle = 1;
    foreach (st[i]) begin
      if (st[i] == 3 || st[i] == 4) any_rd = 1;
      if (!(st[i] == 0 || st[i] == 2 || st[i] == 3 || st[i] == 6)) all_ok = 0;
      if (st[i] != 0) all_idle = 0;
    end
    s = st[b];
    case (c)
      0, 1:    lg = 1;
      2:       lg = (s == 2 || s == 3 || s == 5 || s == 6);
      3, 4:    lg = (s == 2 || s == 3);
      5, 6:    lg = (s == 2 || s == 5 || s == 6) && !any_rd;
      7:       lg = (s == 0);
      8:       lg = (s == 0 || s == 2 || s == 3 || s == 6);
      9:       lg = all_ok;
      10:      lg = all_idle;
      default: lg = 0;
    endcase
    for (int i = 0; i < NB; i++) begin
      take = 0;
      if (lg && (i == b || c == 9 || c == 10)) begin
        case (c)
          7:  begin st[i] = 1; rem[i] = T_RCD; take = 1; end
          3:  begin st[i] = 3; rem[i] = BL / 2 + CL; take = 1; end
          4:  begin st[i] = 4; rem[i] = BL / 2 + CL; take = 1; end
          5:  begin st[i] = 5; rem[i] = BL / 2; take = 1; end
          6:  begin st[i] = 7; rem[i] = BL / 2 + T_WR; take = 1; end
          10: begin st[i] = 9; rem[i] = T_RFC; take = 1; end
          2:  if (st[i] == 3 || st[i] == 5) begin st[i] = 2; take = 1; end
          8, 9: if (st[i] != 0) begin st[i] = 8; rem[i] = T_RP; take = 1; end
          default: ;
        endcase
      end
      if (!take && st[i] != 0 && st[i] != 2) begin
        rem[i]--;
        if (rem[i] == 0) begin
          case (st[i])
            1, 3, 6: st[i] = 2;
            5:       begin st[i] = 6; rem[i] = T_WR; end
            4, 7:    begin st[i] = 8; rem[i] = T_RP; end
            default: st[i] = 0;
          endcase
        end
      end
    end
    exp_cmd = c; exp_ill = lg ? 0 : 1; exp_ba = b;
  endtask

  task automatic compare(string tag);
    chk(tag, "cmd_o", int'(cmd_o), exp_cmd);
    chk(tag, "illegal_o", int'(illegal_o), exp_ill);
    chk(tag, "next_state_o", int'(next_state_o), st[exp_ba]);
    for (int i = 0; i < NB; i++) chk(tag, "bank_state", int'(bank_state_o[i*4 +: 4]), st[i]);
  endtask

  task automatic pins(string tag, int cs, int ras, int cas, int we, int b, int a);
    cs_n = 1'(cs); ras_n = 1'(ras); cas_n = 1'(cas); we_n = 1'(we);
    ba = BA_W'(b); a10 = 1'(a);
    @(posedge clk);
    model(cs, ras, cas, we, b, a);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic nop(string tag, int n);
    for (int k = 0; k < n; k++) pins(tag, 0, 1, 1, 1, 0, 0);
  endtask
  task automatic act(string tag, int b);        pins(tag, 0, 0, 1, 1, b, 0); endtask
  task automatic rd(string tag, int b, int ap); pins(tag, 0, 1, 0, 1, b, ap); endtask
  task automatic wr(string tag, int b, int ap); pins(tag, 0, 1, 0, 0, b, ap); endtask
  task automatic bst(string tag, int b);        pins(tag, 0, 1, 1, 0, b, 0); endtask
  task automatic pre(string tag, int b);        pins(tag, 0, 0, 1, 0, b, 0); endtask
  task automatic pall(string tag);              pins(tag, 0, 0, 1, 0, 0, 1); endtask
  task automatic refr(string tag);              pins(tag, 0, 0, 0, 1, 0, 0); endtask

  initial begin
    foreach (st[i]) begin st[i] = 0; rem[i] = 0; end
    repeat (3) @(negedge clk);
    compare("R2");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R2");

    act("R3", 0); act("R3", 0); rd("R3", 0, 0); nop("R3", 3);
    rd("R4", 0, 0); nop("R4", 2); rd("R4", 0, 0); nop("R4", 5);
    wr("R5", 0, 0); nop("R5", 1); wr("R5", 0, 0); nop("R5", 5);
    act("R13", 1); act("R13", 2); nop("R13", 4);
    rd("R10", 0, 0); wr("R10", 1, 0); bst("R10", 0); wr("R10", 0, 0); nop("R10", 5);
    rd("R10", 2, 0); nop("R10", 3); wr("R10", 1, 0); nop("R10", 5);
    wr("R9", 1, 1); rd("R9", 1, 0); act("R9", 1); pre("R9", 1); bst("R9", 1);
    wr("R9", 1, 0); nop("R9", 1); pins("R9", 1, 0, 0, 0, 1, 0); nop("R9", 8);
    rd("R9", 2, 1); wr("R9", 2, 0); pre("R9", 2); nop("R9", 9);
    pre("R6", 0); pre("R6", 0); nop("R6", 4); pre("R6", 0);
    act("R7", 0); act("R7", 3); pall("R7"); nop("R7", 3); pall("R7"); nop("R7", 4);
    act("R8", 1); refr("R8"); nop("R8", 3); pre("R8", 1); nop("R8", 3);
    refr("R8"); act("R8", 0); refr("R8"); pall("R8"); nop("R8", 8);
    pins("R1", 1, 0, 0, 0, 3, 1); pins("R1", 1, 0, 1, 0, 2, 0);
    pins("R1", 0, 0, 0, 0, 1, 0); pins("R1", 0, 0, 0, 0, 1, 1);
    pins("R11", 0, 0, 0, 0, 0, 0); nop("R11", 1);
    // command on the exact edge a timer expires
    for (int g = 0; g < 5; g++) begin
      act("R3", 0); nop("R3", g); rd("R3", 0, 0); nop("R3", g); wr("R4", 0, 0);
      nop("R5", 6); pall("R6"); nop("R6", 4);
    end
    for (int g = 0; g < 6; g++) begin
      act("R13", 1); act("R13", 2); nop("R13", 3); rd("R13", 1, 0);
      nop("R13", g); wr("R10", 2, 0); nop("R10", 6); pall("R7"); nop("R7", 4);
    end
    for (int k = 0; k < 1500; k++)
      pins("R12", ($urandom_range(0, 9) == 0) ? 1 : 0, int'($urandom_range(0, 1)),
           int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
           int'($urandom_range(0, NB - 1)), int'($urandom_range(0, 1)));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule